// File: doc/BRIEF.md
# Single-Precision to Unsigned Integer Converter with Sticky Exception Flags

This block takes a 32-bit IEEE-754 single-precision operand and produces a 32-bit unsigned integer. A 2-bit control input selects how any fractional part is rounded. Special values follow fixed rules. Subnormal operands are treated as zero and raise a flush flag. NaN, infinities and negative values whose magnitude rounds to a nonzero integer saturate to fixed results and raise the invalid flag. A finite positive operand too large for 32 bits also saturates and raises the invalid flag.

The unit is a three-stage pipeline that can take one operation per clock. A valid bit, a guard bit and a destination tag travel with each operation. When the guard bit is 0, the operation still flows through the pipeline. In that case it neither replaces the held result nor touches the flags.

The block also holds a sticky status register with three exception flags. In a single cycle this register takes the OR of the guarded update from this unit and the updates from other floating-point units working in parallel. Flags are cleared only by an explicit software write, and that write wins over any update that lands in the same cycle.

Top module: `f2u_conv`

## Requirements
- R1: Rounding mode encoding is 00 = nearest with ties to even, 01 = toward zero, 10 = toward +infinity, 11 = toward -infinity. In-range positive operands give the rounded integer. The inexact flag (status bit 0) is set exactly when a fraction was discarded. Examples: 3.0 gives 3 with no flag. 2.57 gives 3 (modes 00 and 10) or 2 (modes 01 and 11) with inexact. 2.5 gives 2 and 3.5 gives 4 in mode 00.
- R2: A subnormal operand gives result 0 and sets only the flush flag (status bit 2).
- R3: A negative operand whose magnitude rounds to a nonzero integer gives 0 and sets only the invalid flag (status bit 1). A negative operand that rounds to 0 gives 0 and sets only inexact, and only if a fraction was discarded. Negative zero gives 0 with no flag.
- R4: Positive infinity, or a positive finite value of 2^32 or more, gives 0xFFFFFFFF and sets only the invalid flag. The value 0x4F7FFFFF converts exactly to 0xFFFFFF00.
- R5: Quiet NaN, signaling NaN and negative infinity all give 0 and set only the invalid flag.
- R6: An operation sampled at clock edge k appears on out_valid, out_tag and out_result after edge k+3. The status update appears at the same edge. A new operation is accepted every cycle.
- R7: When in_guard is 0, out_valid still rises, but out_we stays 0, out_result keeps its previous value and no status flag changes.
- R8: Status flags are sticky. Once set, a flag stays set until a software write.
- R9: In one cycle, each flag's new value is the OR of its current value, this unit's guarded update and every lane of ext_upd. Each lane is 3 bits in the same bit order, and lane i sits at bits 3i+2..3i.
- R10: When sw_wr is 1, the status register takes sw_flags and ignores every update landing in that cycle.
- R11: During reset, out_valid and out_we are 0, out_result is 0 and all status flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| in_guard | input | 1 | Least significant bit of the guard; 1 commits result and flags |
| in_tag | input | TAG_W | Destination tag carried with the operation |
| in_rm | input | 2 | Rounding mode |
| in_op | input | 32 | Single-precision operand |
| ext_upd | input | 3*N_EXT | Same-cycle flag updates from other units |
| sw_wr | input | 1 | Explicit status write strobe |
| sw_flags | input | 3 | Value loaded by the status write |
| out_valid | output | 1 | An operation leaves the pipeline |
| out_we | output | 1 | The leaving operation was committed |
| out_tag | output | TAG_W | Tag of the leaving operation |
| out_result | output | 32 | Last committed integer result |
| stat_flags | output | 3 | Sticky flags: bit 0 inexact, bit 1 invalid, bit 2 flushed |

## Verification
On every cycle, the assertions check several properties. They check the fixed three-cycle latency and tag alignment, and that the result holds whenever nothing is committed. They check that flags never drop without a software write, and that a software write overrides any update in the same cycle. They also check that a committed event never raises invalid together with inexact, that flush always comes alone with a zero result, and that any invalid result is one of the two saturation values. Only the bench's scenarios show the actual integer values under each rounding mode, including tie breaking. The same holds for the split between negative values that round to zero and those that do not, the exact saturation boundary near 2^32, and the OR-merge of external lanes.

// File: rtl/f2u_pkg.sv
package f2u_pkg;
  localparam int FW    = 3;
  localparam int FL_NX = 0;
  localparam int FL_NV = 1;
  localparam int FL_FZ = 2;

  typedef enum logic [2:0] {C_ZERO, C_SUB, C_NORM, C_INF, C_NAN} cls_e;
  typedef enum logic [1:0] {RM_NE = 2'b00, RM_TZ = 2'b01, RM_UP = 2'b10, RM_DN = 2'b11} rmode_e;

  function automatic cls_e classify(input logic [7:0] e, input logic [22:0] f);
    if (e == 8'd0)        return (f == '0) ? C_ZERO : C_SUB;
    else if (e == 8'hFF)  return (f == '0) ? C_INF : C_NAN;
    else                  return C_NORM;
  endfunction

  // Returns {integer part, round bit, sticky bit} for a normal operand
  // whose biased exponent is at most 158.
  function automatic logic [33:0] align_mag(input logic [7:0] e, input logic [23:0] m);
    logic [87:0] w;
    if (e > 8'd158) return '0;
    if (e < 8'd126) return {32'd0, 1'b0, 1'b1};
    w = {m, 64'd0} >> (8'd182 - e);
    return {w[63:32], w[31], |w[30:0]};
  endfunction

  function automatic logic round_inc(input rmode_e rm, input logic neg,
                                     input logic lsb, input logic r, input logic s);
    case (rm)
      RM_NE:   return r & (s | lsb);
      RM_TZ:   return 1'b0;
      RM_UP:   return (r | s) & ~neg;
      default: return (r | s) & neg;
    endcase
  endfunction
endpackage

// File: rtl/f2u_unpack.sv
module f2u_unpack
  import f2u_pkg::*;
(
  input  logic [31:0] op,
  output cls_e        cls,
  output logic [23:0] mant
);
  always_comb begin
    cls  = classify(op[30:23], op[22:0]);
    mant = {(cls == C_NORM), op[22:0]};
  end
endmodule

// File: rtl/f2u_align.sv
module f2u_align
  import f2u_pkg::*;
(
  input  logic [7:0]  exp_b,
  input  logic [23:0] mant,
  output logic [31:0] mag,
  output logic        rnd,
  output logic        stk,
  output logic        big
);
  always_comb begin
    {mag, rnd, stk} = align_mag(exp_b, mant);
    big             = (exp_b > 8'd158);
  end
endmodule

// File: rtl/f2u_finish.sv
module f2u_finish
  import f2u_pkg::*;
(
  input  cls_e           cls,
  input  logic           sign,
  input  logic           big,
  input  logic [31:0]    mag,
  input  logic           rnd,
  input  logic           stk,
  input  rmode_e         rm,
  output logic [31:0]    res,
  output logic [FW-1:0]  flags
);
  logic [32:0] sum;

  always_comb begin
    sum   = {1'b0, mag} + {32'd0, round_inc(rm, sign, mag[0], rnd, stk)};
    res   = '0;
    flags = '0;
    case (cls)
      C_ZERO: ;
      C_SUB:  flags[FL_FZ] = 1'b1;
      C_NAN:  flags[FL_NV] = 1'b1;
      C_INF: begin
        flags[FL_NV] = 1'b1;
        res          = sign ? 32'd0 : 32'hFFFF_FFFF;
      end
      default: begin
        if (big) begin
          flags[FL_NV] = 1'b1;
          res          = sign ? 32'd0 : 32'hFFFF_FFFF;
        end else if (sign) begin
          if (sum != '0) flags[FL_NV] = 1'b1;
          else           flags[FL_NX] = rnd | stk;
        end else if (sum[32]) begin
          flags[FL_NV] = 1'b1;
          res          = 32'hFFFF_FFFF;
        end else begin
          res          = sum[31:0];
          flags[FL_NX] = rnd | stk;
        end
      end
    endcase
  end
endmodule

// File: rtl/f2u_status.sv
module f2u_status
  import f2u_pkg::*;
#(
  parameter int N_EXT = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [FW-1:0]       loc_upd,
  input  logic [N_EXT*FW-1:0] ext_upd,
  input  logic                sw_wr,
  input  logic [FW-1:0]       sw_flags,
  output logic [FW-1:0]       flags
);
  logic [FW-1:0] chain [N_EXT+1];

  assign chain[0] = loc_upd;
  for (genvar i = 0; i < N_EXT; i++) begin : g_lane
    assign chain[i+1] = chain[i] | ext_upd[i*FW +: FW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     flags <= '0;
    else if (sw_wr) flags <= sw_flags;
    else            flags <= flags | chain[N_EXT];
  end
endmodule

// File: rtl/f2u_conv.sv
module f2u_conv
  import f2u_pkg::*;
#(
  parameter int TAG_W = 5,
  parameter int N_EXT = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_guard,
  input  logic [TAG_W-1:0]    in_tag,
  input  logic [1:0]          in_rm,
  input  logic [31:0]         in_op,
  input  logic [N_EXT*FW-1:0] ext_upd,
  input  logic                sw_wr,
  input  logic [FW-1:0]       sw_flags,
  output logic                out_valid,
  output logic                out_we,
  output logic [TAG_W-1:0]    out_tag,
  output logic [31:0]         out_result,
  output logic [FW-1:0]       stat_flags
);
  // stage 0 -> 1: classify
  cls_e        u_cls;
  logic [23:0] u_mant;
  f2u_unpack u_unpack (.op(in_op), .cls(u_cls), .mant(u_mant));

  logic             s1_v, s1_g, s1_sign;
  logic [TAG_W-1:0] s1_tag;
  rmode_e           s1_rm;
  logic [7:0]       s1_exp;
  logic [23:0]      s1_mant;
  cls_e             s1_cls;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_g <= 1'b0; s1_sign <= 1'b0; s1_tag <= '0;
      s1_rm <= RM_NE; s1_exp <= '0; s1_mant <= '0; s1_cls <= C_ZERO;
    end else begin
      s1_v    <= in_valid;
      s1_g    <= in_guard;
      s1_sign <= in_op[31];
      s1_tag  <= in_tag;
      s1_rm   <= rmode_e'(in_rm);
      s1_exp  <= in_op[30:23];
      s1_mant <= u_mant;
      s1_cls  <= u_cls;
    end
  end

  // stage 1 -> 2: align to fixed point
  logic [31:0] a_mag;
  logic        a_rnd, a_stk, a_big;
  f2u_align u_align (.exp_b(s1_exp), .mant(s1_mant), .mag(a_mag),
                     .rnd(a_rnd), .stk(a_stk), .big(a_big));

  logic             s2_v, s2_g, s2_sign, s2_rnd, s2_stk, s2_big;
  logic [TAG_W-1:0] s2_tag;
  rmode_e           s2_rm;
  logic [31:0]      s2_mag;
  cls_e             s2_cls;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v <= 1'b0; s2_g <= 1'b0; s2_sign <= 1'b0; s2_rnd <= 1'b0;
      s2_stk <= 1'b0; s2_big <= 1'b0; s2_tag <= '0; s2_rm <= RM_NE;
      s2_mag <= '0; s2_cls <= C_ZERO;
    end else begin
      s2_v    <= s1_v;
      s2_g    <= s1_g;
      s2_sign <= s1_sign;
      s2_rnd  <= a_rnd;
      s2_stk  <= a_stk;
      s2_big  <= a_big;
      s2_tag  <= s1_tag;
      s2_rm   <= s1_rm;
      s2_mag  <= a_mag;
      s2_cls  <= s1_cls;
    end
  end

  // stage 2 -> 3: round, saturate, commit
  logic [31:0]   evt_res;
  logic [FW-1:0] evt_flags;
  logic          evt_we;
  logic [FW-1:0] loc_upd;

  f2u_finish u_finish (.cls(s2_cls), .sign(s2_sign), .big(s2_big), .mag(s2_mag),
                       .rnd(s2_rnd), .stk(s2_stk), .rm(s2_rm),
                       .res(evt_res), .flags(evt_flags));

  assign evt_we  = s2_v & s2_g;
  assign loc_upd = evt_we ? evt_flags : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_we <= 1'b0; out_tag <= '0; out_result <= '0;
    end else begin
      out_valid <= s2_v;
      out_we    <= evt_we;
      out_tag   <= s2_tag;
      if (evt_we) out_result <= evt_res;
    end
  end

  f2u_status #(.N_EXT(N_EXT)) u_status (
    .clk(clk), .rst_n(rst_n), .loc_upd(loc_upd), .ext_upd(ext_upd),
    .sw_wr(sw_wr), .sw_flags(sw_flags), .flags(stat_flags));
endmodule

// File: rtl/f2u_conv_chk.sv
module f2u_conv_chk
  import f2u_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [TAG_W-1:0] in_tag,
  input logic             sw_wr,
  input logic [FW-1:0]    sw_flags,
  input logic             out_valid,
  input logic             out_we,
  input logic [TAG_W-1:0] out_tag,
  input logic [31:0]      out_result,
  input logic [FW-1:0]    stat_flags,
  input logic             evt_we,
  input logic [31:0]      evt_res,
  input logic [FW-1:0]    evt_flags
);
  // R6
  latency_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 (out_valid && out_tag == $past(in_tag, 3)));
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_we |-> $stable(out_result));
  // R7
  we_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> out_valid);
  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr |=> ((stat_flags & $past(stat_flags)) == $past(stat_flags)));
  // R9
  merge_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr && evt_we) |=> ((stat_flags & $past(evt_flags)) == $past(evt_flags)));
  // R10
  sw_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> (stat_flags == $past(sw_flags)));
  // R3
  nv_nx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_we |-> !(evt_flags[FL_NV] && evt_flags[FL_NX]));
  // R2
  flush_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_we && evt_flags[FL_FZ]) |-> (evt_res == 32'd0 && $countones(evt_flags) == 1));
  // R4
  sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_we && evt_flags[FL_NV]) |-> (evt_res == 32'd0 || evt_res == 32'hFFFF_FFFF));
endmodule

bind f2u_conv f2u_conv_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
  .sw_wr(sw_wr), .sw_flags(sw_flags), .out_valid(out_valid), .out_we(out_we),
  .out_tag(out_tag), .out_result(out_result), .stat_flags(stat_flags),
  .evt_we(evt_we), .evt_res(evt_res), .evt_flags(evt_flags));

// File: tb/tb_f2u_conv.sv
module tb_f2u_conv;
  localparam int TAG_W = 5;
  localparam int N_EXT = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_guard = 1'b0;
  logic [TAG_W-1:0] in_tag = '0;
  logic [1:0]       in_rm = 2'b00;
  logic [31:0]      in_op = '0;
  logic [N_EXT*3-1:0] ext_upd = '0;
  logic             sw_wr = 1'b0;
  logic [2:0]       sw_flags = '0;
  logic             out_valid, out_we;
  logic [TAG_W-1:0] out_tag;
  logic [31:0]      out_result;
  logic [2:0]       stat_flags;

  int n_chk = 0;
  int n_fail = 0;

  f2u_conv #(.TAG_W(TAG_W), .N_EXT(N_EXT)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_guard(in_guard),
    .in_tag(in_tag), .in_rm(in_rm), .in_op(in_op), .ext_upd(ext_upd),
    .sw_wr(sw_wr), .sw_flags(sw_flags), .out_valid(out_valid), .out_we(out_we),
    .out_tag(out_tag), .out_result(out_result), .stat_flags(stat_flags));

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_flags();
    @(negedge clk); sw_wr = 1'b1; sw_flags = 3'b000;
    @(negedge clk); sw_wr = 1'b0;
  endtask

  // drive one operation, return after the third edge that follows
  task automatic issue(input logic [31:0] op, input logic [1:0] rm,
                       input logic g, input logic [TAG_W-1:0] tag);
    @(negedge clk);
    in_valid = 1'b1; in_guard = g; in_op = op; in_rm = rm; in_tag = tag;
    @(negedge clk); in_valid = 1'b0; in_guard = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic conv(input string req, input logic [31:0] op, input logic [1:0] rm,
                      input logic [31:0] er, input logic [2:0] ef);
    clear_flags();
    issue(op, rm, 1'b1, 5'd7);
    check(req, out_result, er);
    check(req, {29'd0, stat_flags}, {29'd0, ef});
  endtask

  task automatic t_reset();
    check("R11 valid", {31'd0, out_valid}, 32'd0);
    check("R11 we", {31'd0, out_we}, 32'd0);
    check("R11 result", out_result, 32'd0);
    check("R11 flags", {29'd0, stat_flags}, 32'd0);
  endtask

  task automatic t_rounding();
    conv("R1 3.0", 32'h4040_0000, 2'b00, 32'd3, 3'b000);
    conv("R1 1.0", 32'h3F80_0000, 2'b01, 32'd1, 3'b000);
    conv("R1 2.57 ne", 32'h4024_7AE1, 2'b00, 32'd3, 3'b001);
    conv("R1 2.57 tz", 32'h4024_7AE1, 2'b01, 32'd2, 3'b001);
    conv("R1 2.57 up", 32'h4024_7AE1, 2'b10, 32'd3, 3'b001);
    conv("R1 2.57 dn", 32'h4024_7AE1, 2'b11, 32'd2, 3'b001);
    conv("R1 2.5 tie", 32'h4020_0000, 2'b00, 32'd2, 3'b001);
    conv("R1 3.5 tie", 32'h4060_0000, 2'b00, 32'd4, 3'b001);
    conv("R1 0.5 ne", 32'h3F00_0000, 2'b00, 32'd0, 3'b001);
    conv("R1 0.3 up", 32'h3E99_999A, 2'b10, 32'd1, 3'b001);
  endtask

  task automatic t_denorm();
    conv("R2 denorm", 32'h0040_0000, 2'b00, 32'd0, 3'b100);
    conv("R2 min denorm", 32'h0000_0001, 2'b10, 32'd0, 3'b100);
  endtask

  task automatic t_negative();
    conv("R3 -1.51", 32'hBFC1_47AE, 2'b00, 32'd0, 3'b010);
    conv("R3 -1.51 tz", 32'hBFC1_47AE, 2'b01, 32'd0, 3'b010);
    conv("R3 -max", 32'hFF7F_FFFF, 2'b00, 32'd0, 3'b010);
    conv("R3 -0.3 tz", 32'hBE99_999A, 2'b01, 32'd0, 3'b001);
    conv("R3 -0.3 ne", 32'hBE99_999A, 2'b00, 32'd0, 3'b001);
    conv("R3 -0.3 dn", 32'hBE99_999A, 2'b11, 32'd0, 3'b010);
    conv("R3 -0", 32'h8000_0000, 2'b00, 32'd0, 3'b000);
  endtask

  task automatic t_overflow();
    conv("R4 +inf", 32'h7F80_0000, 2'b00, 32'hFFFF_FFFF, 3'b010);
    conv("R4 2^32", 32'h4F80_0000, 2'b01, 32'hFFFF_FFFF, 3'b010);
    conv("R4 edge", 32'h4F7F_FFFF, 2'b00, 32'hFFFF_FF00, 3'b000);
  endtask

  task automatic t_nan();
    conv("R5 qnan", 32'hFFFF_FFFF, 2'b00, 32'd0, 3'b010);
    conv("R5 snan", 32'hFFBF_FFFF, 2'b00, 32'd0, 3'b010);
    conv("R5 pos qnan", 32'h7FC0_0000, 2'b10, 32'd0, 3'b010);
    conv("R5 -inf", 32'hFF80_0000, 2'b00, 32'd0, 3'b010);
  endtask

  task automatic t_pipeline();
    @(negedge clk); in_valid = 1'b1; in_guard = 1'b1; in_rm = 2'b01;
    in_op = 32'h3F80_0000; in_tag = 5'd1;
    @(negedge clk); in_op = 32'h4040_0000; in_tag = 5'd2;
    @(negedge clk); in_op = 32'h4024_7AE1; in_tag = 5'd3;
    check("R6 not early", {31'd0, out_valid}, 32'd0);
    @(negedge clk); in_valid = 1'b0; in_guard = 1'b0;
    check("R6 tag1", {27'd0, out_tag}, 32'd1);
    check("R6 res1", out_result, 32'd1);
    @(negedge clk);
    check("R6 tag2", {27'd0, out_tag}, 32'd2);
    check("R6 res2", out_result, 32'd3);
    @(negedge clk);
    check("R6 tag3", {27'd0, out_tag}, 32'd3);
    check("R6 res3", out_result, 32'd2);
    @(negedge clk);
    check("R6 drained", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_guard();
    conv("R7 setup", 32'h3F80_0000, 2'b00, 32'd1, 3'b000);
    issue(32'h4024_7AE1, 2'b00, 1'b0, 5'd9);
    check("R7 valid", {31'd0, out_valid}, 32'd1);
    check("R7 we", {31'd0, out_we}, 32'd0);
    check("R7 result kept", out_result, 32'd1);
    check("R7 flags untouched", {29'd0, stat_flags}, 32'd0);
  endtask

  task automatic t_sticky();
    conv("R8 set", 32'h4024_7AE1, 2'b00, 32'd3, 3'b001);
    issue(32'h4040_0000, 2'b00, 1'b1, 5'd4);
    check("R8 kept", {29'd0, stat_flags}, 32'd1);
    issue(32'h7F80_0000, 2'b00, 1'b1, 5'd5);
    check("R8 accum", {29'd0, stat_flags}, 32'd3);
    clear_flags();
    check("R8 cleared", {29'd0, stat_flags}, 32'd0);
  endtask

  task automatic t_merge();
    clear_flags();
    @(negedge clk); in_valid = 1'b1; in_guard = 1'b1; in_op = 32'h4024_7AE1; in_rm = 2'b00;
    @(negedge clk); in_valid = 1'b0; in_guard = 1'b0;
    @(negedge clk); ext_upd = {3'b100, 3'b000, 3'b010};
    @(negedge clk); ext_upd = '0;
    check("R9 merge", {29'd0, stat_flags}, 32'd7);
    clear_flags();
    @(negedge clk); ext_upd = {3'b000, 3'b010, 3'b000};
    @(negedge clk); ext_upd = '0;
    check("R9 ext only", {29'd0, stat_flags}, 32'd2);
  endtask

  task automatic t_priority();
    clear_flags();
    @(negedge clk); in_valid = 1'b1; in_guard = 1'b1; in_op = 32'h4024_7AE1; in_rm = 2'b00;
    @(negedge clk); in_valid = 1'b0; in_guard = 1'b0;
    @(negedge clk); ext_upd = {3'b000, 3'b000, 3'b010}; sw_wr = 1'b1; sw_flags = 3'b100;
    @(negedge clk); ext_upd = '0; sw_wr = 1'b0; sw_flags = 3'b000;
    check("R10 priority", {29'd0, stat_flags}, 32'd4);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_rounding();
    t_denorm();
    t_negative();
    t_overflow();
    t_nan();
    t_pipeline();
    t_guard();
    t_sticky();
    t_merge();
    t_priority();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule